// File: doc/BRIEF.md
# Four-Lane Vector Swizzle Unit

This unit builds a four-lane destination vector out of a four-lane source vector. A 12-bit control field holds one 3-bit selector for each destination lane. A selector can do one of four things:
- copy any chosen source lane;
- write a constant zero;
- write a constant one, whose encoding depends on a float/integer mode bit;
- leave the previous destination lane untouched, which works like a per-lane write mask stored inside the immediate.

Every lane reads the unmodified source at the same time. One source lane can therefore feed several destination lanes, and no ordering hazard arises between lanes.

The 12 control bits arrive scattered through a 32-bit instruction word, and the unit gathers them itself. The result is registered together with a valid flag and an illegal-encoding flag, so the output appears one cycle after the request.

Top module: `swz_unit`

## Requirements
- R1: The result appears one clock after `in_valid` is high. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. A synchronous active-high reset clears `out_valid` and `out_illegal`.
- R2: The 12-bit immediate is the concatenation {insn[30:29], insn[25:16]}, with insn[30] as its most significant bit. Destination lane k (0=X, 1=Y, 2=Z, 3=W) is controlled by immediate bits [3k+2:3k].
- R3: A selector 0b0NN writes source lane NN into the destination lane. Lanes are 32 bits wide, and lane k occupies bits [32k+31:32k] of the vector ports.
- R4: Selector 0b100 writes 0x00000000 into the destination lane.
- R5: Selector 0b101 writes 0x3F800000 when `float_mode` is 1 and 0x00000001 when `float_mode` is 0.
- R6: Selector 0b110 (skip) returns the matching lane of `old_dst` unchanged.
- R7: Selector 0b111 is reserved. It acts as skip for its lane. `out_illegal` is high with the result exactly when at least one lane uses 0b111.
- R8: Each lane is decoded independently from the same unmodified source, so one source lane may feed several destination lanes at once.
- R9: The output data and `out_illegal` hold their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word carrying the split immediate |
| float_mode | input | 1 | 1 selects the floating-point constant one |
| src_vec | input | 128 | Source vector, four 32-bit lanes |
| old_dst | input | 128 | Previous destination vector, used by skip lanes |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Swizzled result |
| out_illegal | output | 1 | A reserved selector was used |

## Verification
The hardest case to reach from the ports is a mix of lanes in one request, such as skip next to reserved next to constant next to a duplicated source lane. This matters because a fault in the field gathering or in lane indexing only shows up when neighbouring selectors differ. The bench sweeps every one of the 8^4 immediate combinations through the scattered instruction bits. It fills the bits outside the immediate with noise and uses distinct per-lane data, and it flips `float_mode` on alternate requests. Every result is compared against a model built directly from the requirement text.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned LANE_W  = 32;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned IMM_W   = LANES * SEL_W;
  localparam int unsigned VEC_W   = LANES * LANE_W;

  typedef enum logic [1:0] {
    SRC_COPY,
    SRC_CONST,
    SRC_KEEP
  } lane_kind_e;

  typedef struct packed {
    lane_kind_e kind;
    logic [1:0] idx;
    logic       one;
    logic       bad;
  } lane_ctl_t;
endpackage

// File: rtl/swz_imm_gather.sv
module swz_imm_gather #(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned LO_POS = 16,
  parameter int unsigned LO_W   = 10,
  parameter int unsigned HI_POS = 29,
  parameter int unsigned HI_W   = 2
) (
  input  logic [INSN_W-1:0]    insn,
  output logic [LO_W+HI_W-1:0] imm
);
  assign imm = {insn[HI_POS +: HI_W], insn[LO_POS +: LO_W]};
endmodule

// File: rtl/swz_sel_decode.sv
module swz_sel_decode
  import swz_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output lane_ctl_t        ctl
);
  always_comb begin
    ctl      = '0;
    ctl.kind = SRC_KEEP;
    ctl.idx  = sel[1:0];
    if (!sel[2]) begin
      ctl.kind = SRC_COPY;
    end else begin
      case (sel[1:0])
        2'b00: ctl.kind = SRC_CONST;
        2'b01: begin
          ctl.kind = SRC_CONST;
          ctl.one  = 1'b1;
        end
        2'b10: ctl.kind = SRC_KEEP;
        default: begin
          ctl.kind = SRC_KEEP;
          ctl.bad  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int unsigned W         = LANE_W,
  parameter int unsigned N         = LANES,
  parameter logic [W-1:0] ONE_FP   = W'(32'h3F80_0000),
  parameter logic [W-1:0] ONE_INT  = W'(1)
) (
  input  lane_ctl_t        ctl,
  input  logic             float_mode,
  input  logic [N*W-1:0]   src,
  input  logic [W-1:0]     old_lane,
  output logic [W-1:0]     res
);
  logic [W-1:0] picked;
  logic [W-1:0] konst;

  assign picked = src[ctl.idx*W +: W];
  assign konst  = ctl.one ? (float_mode ? ONE_FP : ONE_INT) : '0;

  always_comb begin
    case (ctl.kind)
      SRC_COPY:  res = picked;
      SRC_CONST: res = konst;
      default:   res = old_lane;
    endcase
  end
endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic              float_mode,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  old_dst,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec,
  output logic              out_illegal
);
  logic [IMM_W-1:0] imm;
  logic [VEC_W-1:0] nxt_vec;
  logic [LANES-1:0] lane_bad;

  swz_imm_gather #(.INSN_W(INSN_W)) u_gather (
    .insn (insn),
    .imm  (imm)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_ctl_t ctl;
    swz_sel_decode u_dec (
      .sel (imm[k*SEL_W +: SEL_W]),
      .ctl (ctl)
    );
    swz_lane_mux u_mux (
      .ctl        (ctl),
      .float_mode (float_mode),
      .src        (src_vec),
      .old_lane   (old_dst[k*LANE_W +: LANE_W]),
      .res        (nxt_vec[k*LANE_W +: LANE_W])
    );
    assign lane_bad[k] = ctl.bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec     <= nxt_vec;
        out_illegal <= |lane_bad;
      end
    end
  end
endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk
  import swz_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [INSN_W-1:0] insn,
  input logic              float_mode,
  input logic [VEC_W-1:0]  src_vec,
  input logic [VEC_W-1:0]  old_dst,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_vec,
  input logic              out_illegal
);
  logic [IMM_W-1:0] c_imm;
  assign c_imm = {insn[30:29], insn[25:16]};

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drops_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_vec_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec) && $stable(out_illegal));
  p_zero_lane0_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_imm[2:0] == 3'b100) |=> out_vec[31:0] == 32'h0);
  p_skip_lane0_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_imm[2:0] == 3'b110) |=> out_vec[31:0] == $past(old_dst[31:0]));
  p_reserved_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_imm[11:9] == 3'b111) |=> out_illegal);
  p_copy_lane3_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && c_imm[11:9] == 3'b000) |=> out_vec[127:96] == $past(src_vec[31:0]));
endmodule

bind swz_unit swz_unit_chk #(.INSN_W(INSN_W)) u_chk (.*);

// File: tb/test_swz_unit.sv
`timescale 1ns/1ps
module test_swz_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  insn;
  logic         float_mode;
  logic [127:0] src_vec;
  logic [127:0] old_dst;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         out_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  swz_unit i_swz_unit (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] put_imm(input logic [11:0] imm, input logic [31:0] noise);
    logic [31:0] w;
    w = noise;
    w[25:16] = imm[9:0];
    w[30:29] = imm[11:10];
    return w;
  endfunction

  function automatic logic [127:0] model(input logic [11:0] imm, input logic fm,
                                         input logic [127:0] s, input logic [127:0] o);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] sel;
      sel = imm[3*k +: 3];
      if (sel[2] == 1'b0)      r[32*k +: 32] = s[32*sel[1:0] +: 32];
      else if (sel == 3'b100)  r[32*k +: 32] = 32'h0;
      else if (sel == 3'b101)  r[32*k +: 32] = fm ? 32'h3F80_0000 : 32'h1;
      else                     r[32*k +: 32] = o[32*k +: 32];
    end
    return r;
  endfunction

  function automatic logic bad_of(input logic [11:0] imm);
    logic b;
    b = 1'b0;
    for (int k = 0; k < 4; k++) if (imm[3*k +: 3] == 3'b111) b = 1'b1;
    return b;
  endfunction

  task automatic issue(input logic [11:0] imm, input logic fm, input string req);
    logic [127:0] s, o;
    logic [31:0] noise;
    noise = $urandom;
    s = {$urandom, $urandom, $urandom, $urandom};
    o = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b1; insn = put_imm(imm, noise); float_mode = fm;
    src_vec = s; old_dst = o;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'b0, out_valid}, 128'd1);
    check(req, out_vec, model(imm, fm, s, o));
    check({req, " illegal"}, {127'b0, out_illegal}, {127'b0, bad_of(imm)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    rst = 1'b1; in_valid = 1'b0; insn = '0; float_mode = 1'b0;
    src_vec = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'b0, out_valid}, 128'd0);
    check("R1 reset illegal", {127'b0, out_illegal}, 128'd0);
    rst = 1'b0;

    // R8: W into X, Y into W, skip middle; plus broadcast of Z
    issue({3'b001, 3'b110, 3'b110, 3'b011}, 1'b0, "R8 W..Y pattern");
    issue({3'b010, 3'b010, 3'b010, 3'b010}, 1'b0, "R8 broadcast");
    issue({3'b101, 3'b101, 3'b100, 3'b101}, 1'b1, "R5 float one");
    issue({3'b101, 3'b101, 3'b100, 3'b101}, 1'b0, "R5 int one");
    issue({3'b111, 3'b000, 3'b000, 3'b000}, 1'b0, "R7 reserved");

    // R9: outputs hold while idle
    held = out_vec;
    src_vec = '1; old_dst = '1; insn = '1;
    @(negedge clk);
    check("R9 hold", out_vec, held);
    check("R1 idle valid", {127'b0, out_valid}, 128'd0);

    // R2 R3 R4 R6 R7: full sweep of all selector combinations
    for (int v = 0; v < 4096; v++)
      issue(v[11:0], v[0] ^ v[5], "R2 R3 R4 R6 R7 sweep");

    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after", {127'b0, out_valid}, 128'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule